// File: doc/BRIEF.md
# Burst-Aware Slave Port Arbiter

This block decides which of several bus masters owns one slave port of a multi-master interconnect. Each master presents a request, an AHB-style transfer type and a burst type. The arbiter registers a one-hot grant and the matching master index. It moves the grant only on cycles where a hand-over cannot break a burst in the middle.

A hand-over may happen in four cases:
- the owning master is not using the port;
- a single transfer completes;
- the last beat of a burst completes;
- the owner has held the port for a configured number of cycles.

The last beat of a fixed-length burst follows from its burst code. Undefined-length bursts can be cut on a configurable beat boundary, or never cut.

Configuration is plain input ports. These ports select:
- round-robin or fixed-priority selection;
- what happens when nobody requests at a hand-over point;
- the fixed default master;
- the slot cycle limit;
- the split length for undefined-length bursts.

Top module: `burst_slot_arbiter`

## Requirements
- R1: `grant` is all-zero or one-hot, and whenever it is non-zero, bit `grant_idx` of it is set. After reset `grant` is 0 and `grant_idx` is 0.
- R2: `grant` changes only on the clock edge that ends a hand-over cycle (R6 to R10). In every other cycle it holds, even if other masters raise requests.
- R3: With `cfg_fixed_prio`=1, a hand-over grants the requesting master with the highest index.
- R4: With `cfg_fixed_prio`=0 (round-robin), a hand-over searches upward from the master after `grant_idx`, wrapping past the top, and grants the first requester. The current owner comes last.
- R5: At a hand-over with no request, `cfg_def_type` decides the result:
  - 0 or 3: no grant, and `grant_idx` keeps its value;
  - 1: the previous grant stays;
  - 2: master `cfg_def_idx` is granted.
- R6: A cycle is a hand-over cycle when the port has no owner, when the owner's request is low, or when the owner's transfer type is IDLE. Transfer codes are 00 IDLE, 01 BUSY, 10 first beat, 11 following beat.
- R7: A completed beat (`ready`=1) of burst code 000 (single) by the owner is a hand-over cycle.
- R8: Fixed-length bursts end on their last completed beat, and that beat is a hand-over cycle. Codes 010/011 end after 4 beats, 100/101 after 8, and 110/111 after 16.
- R9: For burst code 001 (undefined length), `cfg_incr_split` selects the cut point. Value 0 never cuts. Values 1, 2 and 3 make every completed 4th, 8th or 16th beat a hand-over cycle.
- R10: With `cfg_slot_limit`=L>0, the L-th cycle after a grant change is a hand-over cycle. L=0 disables this limit.
- R11: A beat with `ready`=0 is not counted towards R8 or R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | NM | Request per master |
| htrans | input | 2*NM | Transfer type per master, master i at bits [2i+1:2i] |
| hburst | input | 3*NM | Burst type per master, master i at bits [3i+2:3i] |
| ready | input | 1 | Slave completes the current beat |
| cfg_fixed_prio | input | 1 | 0 round-robin, 1 fixed priority |
| cfg_def_type | input | 2 | Policy when nobody requests (R5) |
| cfg_def_idx | input | $clog2(NM) | Fixed default master |
| cfg_slot_limit | input | SLOTW | Slot cycle limit, 0 disables |
| cfg_incr_split | input | 2 | Undefined-length burst split (R9) |
| grant | output | NM | One-hot grant |
| grant_idx | output | $clog2(NM) | Index of the granted or last granted master |

## Verification
The hardest case to reach is a competing request that arrives while the owner is inside a burst. That request has to be held off until exactly the beat count, the slot count or the wait states allow a hand-over.

The bench first places master 0 as sole owner with no burst history. It then raises master 3's request together with master 0's first beat, so that the priority rules alone would hand the grant over at once. It then counts edges to the exact cycle where the hand-over must happen, inserting stalled beats along the way.

// File: rtl/burst_slot_arbiter.sv
module burst_slot_arbiter #(
  parameter int NM    = 4,
  parameter int SLOTW = 8,
  parameter int IW    = (NM > 1) ? $clog2(NM) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NM-1:0]     req,
  input  logic [2*NM-1:0]   htrans,
  input  logic [3*NM-1:0]   hburst,
  input  logic              ready,
  input  logic              cfg_fixed_prio,
  input  logic [1:0]        cfg_def_type,
  input  logic [IW-1:0]     cfg_def_idx,
  input  logic [SLOTW-1:0]  cfg_slot_limit,
  input  logic [1:0]        cfg_incr_split,
  output logic [NM-1:0]     grant,
  output logic [IW-1:0]     grant_idx
);

  localparam logic [1:0] TR_IDLE = 2'b00;
  localparam logic [1:0] TR_NSEQ = 2'b10;

  logic [IW-1:0]    own_idx, nxt_idx, fp_idx, rr_idx;
  logic             own_vld, nxt_vld;
  logic [SLOTW-1:0] slot_cnt;
  logic [3:0]       beat_cnt, beat_num, mask;
  logic [1:0]       cur_tr;
  logic [2:0]       cur_bu;
  logic             active, idle, single, eob, slot_hit, brk_en, rearb, chg;

  assign cur_tr   = htrans[own_idx*2 +: 2];
  assign cur_bu   = hburst[own_idx*3 +: 3];
  assign active   = own_vld && req[own_idx] && cur_tr[1];
  assign idle     = !own_vld || !req[own_idx] || cur_tr == TR_IDLE;
  assign beat_num = (cur_tr == TR_NSEQ) ? 4'd1 : beat_cnt + 4'd1;

  always_comb begin
    brk_en = 1'b1;
    unique case (cur_bu)
      3'b001: begin
        brk_en = cfg_incr_split != 2'd0;
        mask   = (cfg_incr_split == 2'd1) ? 4'd3 :
                 (cfg_incr_split == 2'd2) ? 4'd7 : 4'd15;
      end
      3'b010, 3'b011: mask = 4'd3;
      3'b100, 3'b101: mask = 4'd7;
      3'b110, 3'b111: mask = 4'd15;
      default:        begin mask = 4'd0; brk_en = 1'b0; end
    endcase
  end

  assign single   = active && ready && cur_bu == 3'b000;
  assign eob      = active && ready && brk_en && (beat_num & mask) == 4'd0;
  assign slot_hit = own_vld && cfg_slot_limit != '0 &&
                    slot_cnt >= cfg_slot_limit - SLOTW'(1);
  assign rearb    = idle || single || eob || slot_hit;

  always_comb begin
    fp_idx = '0;
    for (int i = 0; i < NM; i++)
      if (req[i]) fp_idx = IW'(i);
  end

  always_comb begin
    rr_idx = own_idx;
    for (int k = NM; k >= 1; k--)
      if (req[(int'(own_idx) + k) % NM]) rr_idx = IW'((int'(own_idx) + k) % NM);
  end

  always_comb begin
    nxt_idx = own_idx;
    nxt_vld = own_vld;
    if (|req) begin
      nxt_vld = 1'b1;
      nxt_idx = cfg_fixed_prio ? fp_idx : rr_idx;
    end else begin
      unique case (cfg_def_type)
        2'd1:    ;
        2'd2:    begin nxt_vld = 1'b1; nxt_idx = cfg_def_idx; end
        default: nxt_vld = 1'b0;
      endcase
    end
  end

  assign chg = rearb && ((nxt_vld != own_vld) || (nxt_vld && nxt_idx != own_idx));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_idx  <= '0;
      own_vld  <= 1'b0;
      slot_cnt <= '0;
      beat_cnt <= '0;
    end else begin
      if (rearb) begin
        own_idx <= nxt_idx;
        own_vld <= nxt_vld;
      end
      if (chg)                  slot_cnt <= '0;
      else if (slot_cnt != '1)  slot_cnt <= slot_cnt + SLOTW'(1);
      if (chg)                  beat_cnt <= '0;
      else if (active && ready) beat_cnt <= beat_num;
    end
  end

  for (genvar g = 0; g < NM; g++) begin : g_gnt
    assign grant[g] = own_vld && own_idx == IW'(g);
  end
  assign grant_idx = own_idx;

endmodule

// File: rtl/burst_slot_arbiter_chk.sv
module burst_slot_arbiter_chk #(
  parameter int NM = 4,
  parameter int IW = (NM > 1) ? $clog2(NM) : 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic [NM-1:0] req,
  input logic          cfg_fixed_prio,
  input logic [1:0]    cfg_def_type,
  input logic [NM-1:0] grant,
  input logic [IW-1:0] grant_idx,
  input logic          rearb
);
  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(grant)); // R1
  AST_GRANT_IDX: assert property (@(posedge clk) disable iff (!rst_n) (grant != '0) |-> grant[grant_idx]); // R1
  AST_HOLD_OUTSIDE_POINTS: assert property (@(posedge clk) disable iff (!rst_n) !rearb |=> $stable(grant)); // R2
  AST_TOP_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
    (rearb && cfg_fixed_prio && req[NM-1]) |=> grant[NM-1]); // R3
  AST_NO_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (rearb && req == '0 && cfg_def_type == 2'd0) |=> grant == '0); // R5
endmodule

bind burst_slot_arbiter burst_slot_arbiter_chk #(.NM(NM)) u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .cfg_fixed_prio(cfg_fixed_prio),
  .cfg_def_type(cfg_def_type), .grant(grant), .grant_idx(grant_idx), .rearb(rearb)
);

// File: tb/burst_slot_arbiter_test.sv
module burst_slot_arbiter_test;
  localparam int PERIOD = 10;
  localparam int NM = 4;

  logic clk = 0, rst_n = 0;
  logic [NM-1:0] req;
  logic [2*NM-1:0] htrans;
  logic [3*NM-1:0] hburst;
  logic ready, cfg_fixed_prio;
  logic [1:0] cfg_def_type, cfg_def_idx, cfg_incr_split, grant_idx;
  logic [7:0] cfg_slot_limit;
  logic [NM-1:0] grant;
  int n_chk = 0, n_bad = 0;

  burst_slot_arbiter #(.NM(NM)) uut (.*);

  always #(PERIOD/2) clk = ~clk;

  // {fixed_prio, req[3:0], expect_valid, expect_idx[1:0]}
  localparam logic [7:0] VEC [12] = '{
    8'b1_0101_1_10, 8'b1_1111_1_11, 8'b1_0011_1_01, 8'b0_1111_1_10,
    8'b0_1111_1_11, 8'b0_1111_1_00, 8'b0_1010_1_01, 8'b0_1010_1_11,
    8'b0_0000_0_11, 8'b0_0001_1_00, 8'b0_0001_1_00, 8'b1_0000_0_00 };

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(int n = 1);
    repeat (n) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic clear();
    req = '0; htrans = '0; hburst = '0; ready = 1;
    cfg_fixed_prio = 1; cfg_def_type = 0; cfg_def_idx = 0;
    cfg_slot_limit = 0; cfg_incr_split = 0;
  endtask

  task automatic own_m0();
    clear(); step();
    req = 4'b0001; step();
  endtask

  initial begin
    #(PERIOD*200000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    clear();
    @(negedge clk); @(negedge clk);
    chk("R1 reset grant", int'(grant), 0);
    chk("R1 reset idx", int'(grant_idx), 0);
    rst_n = 1;
    @(negedge clk);

    foreach (VEC[i]) begin
      cfg_fixed_prio = VEC[i][7];
      req = VEC[i][6:3];
      step();
      chk($sformatf("R3/R4 vec%0d grant", i), int'(grant),
          VEC[i][2] ? (1 << VEC[i][1:0]) : 0);
      chk($sformatf("R4 vec%0d idx", i), int'(grant_idx), int'(VEC[i][1:0]));
    end

    // INCR4 held against a higher priority request, with one stalled beat
    own_m0();
    chk("R3 setup owner 0", int'(grant), 1);
    htrans[1:0] = 2'b10; hburst[2:0] = 3'b011; req = 4'b1001;
    step(); chk("R2 beat1 hold", int'(grant), 1);
    htrans[1:0] = 2'b11;
    step(); chk("R2 beat2 hold", int'(grant), 1);
    ready = 0;
    step(); chk("R11 stalled beat hold", int'(grant), 1);
    ready = 1;
    step(); chk("R8 beat3 hold", int'(grant), 1);
    step(); chk("R8 INCR4 end hands over", int'(grant), 8);

    // INCR split by 4
    own_m0();
    cfg_incr_split = 1;
    htrans[1:0] = 2'b10; hburst[2:0] = 3'b001; req = 4'b1001;
    step(); htrans[1:0] = 2'b11;
    step(2); chk("R9 INCR split4 beat3 hold", int'(grant), 1);
    step(); chk("R9 INCR split4 cut", int'(grant), 8);

    // INCR never split, slot limit 0 disabled
    own_m0();
    htrans[1:0] = 2'b10; hburst[2:0] = 3'b001; req = 4'b1001;
    step(); htrans[1:0] = 2'b11;
    step(19); chk("R9/R10 never split holds", int'(grant), 1);
    htrans[1:0] = 2'b00;
    step(); chk("R6 owner idle hands over", int'(grant), 8);

    // owner drops request mid burst
    own_m0();
    htrans[1:0] = 2'b10; hburst[2:0] = 3'b001; req = 4'b1001;
    step(); chk("R6 active owner holds", int'(grant), 1);
    htrans[1:0] = 2'b11; req = 4'b1000;
    step(); chk("R6 request dropped hands over", int'(grant), 8);

    // single transfer
    own_m0();
    htrans[1:0] = 2'b10; hburst[2:0] = 3'b000; req = 4'b1001;
    step(); chk("R7 single hands over", int'(grant), 8);

    // slot limit 3
    own_m0();
    cfg_slot_limit = 3;
    htrans[1:0] = 2'b10; hburst[2:0] = 3'b001; req = 4'b1001;
    step(); htrans[1:0] = 2'b11;
    step(); chk("R10 slot limit not reached", int'(grant), 1);
    step(); chk("R10 slot limit breaks", int'(grant), 8);

    // default-master policies
    clear(); cfg_def_type = 2; cfg_def_idx = 2;
    step(); chk("R5 fixed default", int'(grant), 4);
    clear(); req = 4'b0010;
    step(); chk("R5 owner 1", int'(grant), 2);
    req = 0; cfg_def_type = 1;
    step(); chk("R5 last default keeps", int'(grant), 2);
    cfg_def_type = 0;
    step(); chk("R5 no default", int'(grant), 0);
    chk("R5 idx kept", int'(grant_idx), 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule